// File: doc/BRIEF.md
# Debug Packet Framer

This block stands between a console byte producer and a serial transmitter. In packet mode it gathers a group of console bytes into a local store. It then sends them as a debugger output packet: a `$` and an `O`, then each byte as two lowercase hex digits, then `#` and a two-digit checksum. After the packet it waits for a reply character. It sends the same packet again until that reply is `+`. Only after the `+` does it accept the next group.

A second mode bypasses the packet format. Each byte goes straight to the transmitter, and a line feed always follows a carriage return. The transmitter side is a valid/ready pair in which ready means the transmit data register is empty. Received characters arrive with a single error flag, which covers parity, framing and overrun faults.

Top module: `dbg_pkt_tx`

## Requirements
- R1: A packet opens with the character `$` (0x24) and then `O` (0x4F).
- R2: Each stored byte goes out as two characters, the high nibble first. Nibble values 0 to 9 map to 0x30 to 0x39, and 10 to 15 map to lowercase 0x61 to 0x66. No run-length compression is applied.
- R3: The checksum starts at 0x4F. It adds the code of every hex character in the payload, modulo 256, and goes out as two lowercase hex characters, the high nibble first.
- R4: The payload is followed by `#` (0x23), and the checksum comes after it.
- R5: Once the last checksum character is accepted, the block waits for one error-free received character. A character received in the same cycle as that last acceptance is not considered. Any character other than `+` makes the block resend the entire packet unchanged.
- R6: `in_ready` stays low from the byte that closes a group until a `+` (0x2B) is received. It is high again in the next cycle.
- R7: A received character with `rx_err` high is dropped. The block keeps waiting and sends nothing.
- R8: With `raw_mode` high when a group starts, each byte is sent unchanged. A byte of 0x0A is sent after a 0x0D.
- R9: A character is transferred only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R10: The store holds up to DEPTH bytes (64 by default). The DEPTH-th byte closes the group even if `in_last` is low.
- R11: After reset, `in_ready` is high and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_mode | input | 1 | Selects bypass mode for a group that is starting |
| in_valid | input | 1 | Console byte valid |
| in_ready | output | 1 | Block can take a console byte |
| in_data | input | 8 | Console byte |
| in_last | input | 1 | Marks the final byte of a packet-mode group |
| tx_valid | output | 1 | Character offered to the transmitter |
| tx_ready | input | 1 | Transmit data register empty |
| tx_data | output | 8 | Character to transmit |
| rx_valid | input | 1 | Received character valid |
| rx_data | input | 8 | Received character |
| rx_err | input | 1 | Received character carries a parity, framing or overrun error |

## Verification
Reception of the reply can fall in the same cycle as the handshake of the final checksum character. In that cycle the block is still sending, so the reply must be ignored. The bench drives a `+` into the receive port in exactly that handshake cycle. It then checks that `in_ready` stays low and that nothing more is sent, and that a later `+` releases the block. Payloads are random bytes drawn from a fixed seed, and the transmitter stalls are random. Every output character is compared with a packet that the bench builds itself, and each stall is checked for a held character.

// File: rtl/dbg_pkt_pkg.sv
package dbg_pkt_pkg;

    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_TAG    = 8'h4F;
    localparam logic [7:0] CH_HASH   = 8'h23;
    localparam logic [7:0] CH_PLUS   = 8'h2B;
    localparam logic [7:0] CH_LF     = 8'h0A;
    localparam logic [7:0] CH_CR     = 8'h0D;

    typedef enum logic [2:0] {
        PH_START, PH_TAG, PH_HI, PH_LO, PH_HASH, PH_SUM_HI, PH_SUM_LO
    } phase_e;

    typedef enum logic [1:0] {
        ST_FILL, ST_SEND, ST_WAIT, ST_RAW
    } state_e;

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h57 + {4'h0, n});
    endfunction

endpackage

// File: rtl/dbg_pkt_store.sv
module dbg_pkt_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

    // R10
    store_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/dbg_pkt_emit.sv
module dbg_pkt_emit
    import dbg_pkt_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          fire,
    input  logic [AW-1:0] len,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic [7:0]    ch,
    output logic          last
);
    phase_e        phase;
    logic [AW-1:0] idx;
    logic [7:0]    sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_START;
            idx   <= '0;
            sum   <= '0;
        end else if (start) begin
            phase <= PH_START;
            idx   <= '0;
        end else if (fire) begin
            case (phase)
                PH_START:  phase <= PH_TAG;
                PH_TAG: begin
                    sum   <= CH_TAG;
                    phase <= PH_HI;
                end
                PH_HI: begin
                    sum   <= sum + hex_char(rd_data[7:4]);
                    phase <= PH_LO;
                end
                PH_LO: begin
                    sum <= sum + hex_char(rd_data[3:0]);
                    if (idx + 1'b1 == len) begin
                        phase <= PH_HASH;
                    end else begin
                        idx   <= idx + 1'b1;
                        phase <= PH_HI;
                    end
                end
                PH_HASH:   phase <= PH_SUM_HI;
                PH_SUM_HI: phase <= PH_SUM_LO;
                default:   phase <= PH_START;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_START:  ch = CH_DOLLAR;
            PH_TAG:    ch = CH_TAG;
            PH_HI:     ch = hex_char(rd_data[7:4]);
            PH_LO:     ch = hex_char(rd_data[3:0]);
            PH_HASH:   ch = CH_HASH;
            PH_SUM_HI: ch = hex_char(sum[7:4]);
            default:   ch = hex_char(sum[3:0]);
        endcase
    end

    assign rd_addr = idx;
    assign last    = (phase == PH_SUM_LO);

    // R2
    hex_set_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI || phase == PH_LO || phase == PH_SUM_HI || phase == PH_SUM_LO)
        |-> ((ch >= 8'h30 && ch <= 8'h39) || (ch >= 8'h61 && ch <= 8'h66)));
endmodule

// File: rtl/dbg_pkt_tx.sv
module dbg_pkt_tx
    import dbg_pkt_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       raw_mode,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_err
);
    localparam int AW = $clog2(DEPTH + 1);

    state_e        state;
    logic [AW-1:0] cnt;
    logic [7:0]    raw_byte;
    logic          cr_pend;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [7:0]    emit_ch;
    logic          emit_last;

    logic accept, go_raw, wr_en, close, fire, emit_fire, reply, restart;

    assign in_ready  = (state == ST_FILL);
    assign accept    = in_valid && in_ready;
    assign go_raw    = accept && raw_mode && (cnt == '0);
    assign wr_en     = accept && !go_raw;
    assign close     = wr_en && (in_last || cnt == AW'(DEPTH - 1));
    assign tx_valid  = (state == ST_SEND) || (state == ST_RAW);
    assign fire      = tx_valid && tx_ready;
    assign emit_fire = fire && (state == ST_SEND);
    assign reply     = (state == ST_WAIT) && rx_valid && !rx_err;
    assign restart   = close || (reply && rx_data != CH_PLUS);
    assign tx_data   = (state == ST_RAW) ? (cr_pend ? CH_CR : raw_byte) : emit_ch;

    dbg_pkt_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (cnt),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dbg_pkt_emit #(.AW(AW)) u_emit (
        .clk     (clk),
        .rst     (rst),
        .start   (restart),
        .fire    (emit_fire),
        .len     (cnt),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .ch      (emit_ch),
        .last    (emit_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            cnt      <= '0;
            raw_byte <= '0;
            cr_pend  <= 1'b0;
        end else begin
            case (state)
                ST_FILL: begin
                    if (go_raw) begin
                        raw_byte <= in_data;
                        cr_pend  <= (in_data == CH_LF);
                        state    <= ST_RAW;
                    end else if (wr_en) begin
                        cnt <= cnt + 1'b1;
                        if (close) state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (emit_fire && emit_last) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (reply) begin
                        if (rx_data == CH_PLUS) begin
                            state <= ST_FILL;
                            cnt   <= '0;
                        end else begin
                            state <= ST_SEND;
                        end
                    end
                end
                default: begin
                    if (fire) begin
                        if (cr_pend) cr_pend <= 1'b0;
                        else         state   <= ST_FILL;
                    end
                end
            endcase
        end
    end

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !in_ready);

    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && rx_valid && !rx_err && rx_data == CH_PLUS) |=> in_ready);

    // R7
    err_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && rx_valid && rx_err) |=> (!tx_valid && !in_ready));

    // R8
    cr_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAW && fire && cr_pend) |=> (tx_valid && tx_data == CH_LF));
endmodule

// File: tb/tb_dbg_pkt_tx.sv
module tb_dbg_pkt_tx;
    logic       clk = 0;
    logic       rst = 1;
    logic       raw_mode = 0;
    logic       in_valid = 0;
    logic       in_ready;
    logic [7:0] in_data = 0;
    logic       in_last = 0;
    logic       tx_valid;
    logic       tx_ready = 0;
    logic [7:0] tx_data;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rx_err = 0;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    logic [7:0] pay [64];
    logic [7:0] got [$];
    logic [7:0] expq [$];

    always #5 clk = ~clk;

    dbg_pkt_tx #(.DEPTH(64)) dut (
        .clk(clk), .rst(rst), .raw_mode(raw_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hx(input logic [3:0] n);
        if (n < 10) return 8'h30 + 8'(n);
        return 8'h61 + 8'(n) - 8'd10;
    endfunction

    task automatic build_pkt(input int n);
        logic [7:0] s;
        expq.delete();
        expq.push_back(8'h24);
        expq.push_back(8'h4F);
        s = 8'h4F;
        for (int i = 0; i < n; i++) begin
            expq.push_back(hx(pay[i][7:4]));
            expq.push_back(hx(pay[i][3:0]));
            s = s + hx(pay[i][7:4]) + hx(pay[i][3:0]);
        end
        expq.push_back(8'h23);
        expq.push_back(hx(s[7:4]));
        expq.push_back(hx(s[3:0]));
    endtask

    task automatic build_raw(input int n);
        expq.delete();
        for (int i = 0; i < n; i++) begin
            if (pay[i] == 8'h0A) expq.push_back(8'h0D);
            expq.push_back(pay[i]);
        end
    endtask

    task automatic push(input logic [7:0] d, input bit l);
        bit acc;
        @(negedge clk);
        in_valid = 1; in_data = d; in_last = l;
        acc = 0;
        while (!acc) begin
            #1 acc = in_ready;
            @(posedge clk);
            if (!acc) @(negedge clk);
        end
        #1 in_valid = 0; in_last = 0;
    endtask

    task automatic push_all(input int n, input bit use_last);
        for (int i = 0; i < n; i++) push(pay[i], use_last && (i == n - 1));
    endtask

    task automatic collect(input int n, input bit plus_at_end);
        bit stalled;
        logic [7:0] sd;
        got.delete();
        stalled = 0;
        sd = 0;
        while (got.size() < n) begin
            @(negedge clk);
            if (stalled) chk(tx_valid && tx_data == sd, "R9 hold", int'(tx_data), int'(sd));
            tx_ready = ($urandom % 3) != 0;
            #1;
            stalled = tx_valid && !tx_ready;
            sd = tx_data;
            if (tx_valid && tx_ready) begin
                got.push_back(tx_data);
                if (plus_at_end && got.size() == n) begin
                    rx_valid = 1; rx_data = 8'h2B; rx_err = 0;
                end
            end
        end
        @(posedge clk);
        #1 rx_valid = 0; tx_ready = 0;
    endtask

    task automatic compare_pkt(input int n);
        string r;
        for (int i = 0; i < expq.size(); i++) begin
            if (i < 2) r = "R1";
            else if (i < 2 + 2 * n) r = "R2";
            else if (i == 2 + 2 * n) r = "R4";
            else r = "R3";
            chk(got[i] == expq[i], r, int'(got[i]), int'(expq[i]));
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input bit e);
        @(negedge clk);
        rx_valid = 1; rx_data = d; rx_err = e;
        @(posedge clk);
        #1 rx_valid = 0; rx_err = 0;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        tx_ready = 1;
        repeat (3) @(negedge clk);
        chk(!tx_valid, req, int'(tx_valid), 0);
        chk(!in_ready, req, int'(in_ready), 0);
        tx_ready = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(in_ready == 1, "R11", int'(in_ready), 1);
        chk(tx_valid == 0, "R11", int'(tx_valid), 0);

        // directed packet with edge byte values
        pay[0] = 8'h0A; pay[1] = 8'hFF; pay[2] = 8'h00; pay[3] = 8'h9A;
        push_all(4, 1);
        build_pkt(4);
        collect(expq.size(), 0);
        compare_pkt(4);
        idle_check("R6");
        // R7 errored characters dropped, even a '+'
        send_rx(8'h2B, 1);
        send_rx(8'h2D, 1);
        idle_check("R7");
        // R5 non-ack resends identical packet
        send_rx(8'h78, 0);
        collect(expq.size(), 0);
        compare_pkt(4);
        // R6 ack releases input
        send_rx(8'h2B, 0);
        @(negedge clk);
        chk(in_ready == 1, "R6", int'(in_ready), 1);

        // random packets
        for (int k = 0; k < 6; k++) begin
            int n;
            n = 1 + int'($urandom % 10);
            for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
            push_all(n, 1);
            build_pkt(n);
            collect(expq.size(), k == 2);
            compare_pkt(n);
            // R5 a '+' at the final handshake is not yet a reply (k == 2)
            idle_check("R5");
            if (k == 4) begin
                send_rx(8'h2D, 0);
                collect(expq.size(), 0);
                compare_pkt(n);
            end
            send_rx(8'h2B, 0);
            @(negedge clk);
            chk(in_ready == 1, "R6", int'(in_ready), 1);
        end

        // R10 full store closes without in_last
        for (int i = 0; i < 64; i++) pay[i] = 8'($urandom);
        push_all(64, 0);
        @(negedge clk);
        chk(in_ready == 0, "R10", int'(in_ready), 0);
        build_pkt(64);
        chk(expq.size() == 133, "R10 size", expq.size(), 133);
        collect(expq.size(), 0);
        compare_pkt(64);
        send_rx(8'h2B, 0);
        @(negedge clk);
        chk(in_ready == 1, "R6", int'(in_ready), 1);

        // R8 bypass mode with line feeds
        raw_mode = 1;
        pay[0] = 8'h41; pay[1] = 8'h0A; pay[2] = 8'h0A; pay[3] = 8'h24;
        pay[4] = 8'h0D; pay[5] = 8'h0A;
        for (int i = 6; i < 12; i++) pay[i] = 8'($urandom);
        build_raw(12);
        fork
            push_all(12, 0);
            collect(expq.size(), 0);
        join
        for (int i = 0; i < expq.size(); i++)
            chk(got[i] == expq[i], "R8", int'(got[i]), int'(expq[i]));
        repeat (2) @(negedge clk);
        chk(!tx_valid && in_ready, "R8 idle", int'({tx_valid, in_ready}), 1);
        raw_mode = 0;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule